// File: doc/BRIEF.md
# Rank Activate Rate Limiter

This block sits beside the command scheduler of a memory controller and decides, cycle by cycle, whether a row activate may be sent to the rank. It enforces two rules that hold across all banks of the rank. The first is a minimum spacing between any two activates. The second is a cap on how many activates may fall inside a sliding window of a fixed number of cycles. The scheduler looks at `allow_o`. It raises `act_i` for one cycle to issue an activate. An activate raised while `allow_o` is high is accepted.

The block keeps the issue times of the most recent accepted activates in a small circular history, one slot per permitted activate. It compares them with a free-running cycle count. When an entry ages out of the window it is marked stale and stays stale, so wraparound of the counter can never make an old entry look recent. Setting the window length to zero removes the history entirely, and then only the spacing rule remains. An activate presented while it is not allowed is refused. The refusal leaves no trace in the timing state and is reported on a one-cycle flag.

Top module: `act_limiter`

## Requirements
- R1: After reset, `allow_o` is 1 and `viol_o` is 0 until the first activate.
- R2: After an activate is accepted in cycle t, `allow_o` is 0 in cycles t+1 through t+RRD_CYC-1 and no longer held low by spacing from cycle t+RRD_CYC on.
- R3: With XAW_CYC > 0, an activate in cycle c is allowed only if fewer than ACT_LIMIT accepted activates were issued in cycles t with c - t < XAW_CYC. An activate exactly XAW_CYC cycles old no longer counts.
- R4: While fewer than ACT_LIMIT activates lie inside the window, the window rule does not lower `allow_o`. This includes the time before the history has ever filled.
- R5: With XAW_CYC = 0 the window rule is disabled and `allow_o` depends on the spacing rule alone.
- R6: ACT_LIMIT is a parameter. With ACT_LIMIT = 2, the third activate inside a window is held off until the oldest of the two ages out.
- R7: When `act_i` is 1 while `allow_o` is 0, `viol_o` is 1 in the next cycle, and the refused activate changes neither the spacing nor the window state.
- R8: When `act_i` is 1 while `allow_o` is 1, or `act_i` is 0, `viol_o` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| act_i | input | 1 | Activate issued this cycle |
| allow_o | output | 1 | An activate in this cycle would be accepted |
| viol_o | output | 1 | Previous cycle's activate was refused |

## Verification
The spacing rule and the window rule can both release in the same cycle. With the default setting, a strobe held high gives accepts at 0, 5, 10 and 15, then at 32, 37, 42 and 47. Cycle 37 is where the spacing timeout and the expiry of the entry from cycle 5 coincide. The bench provokes this with long stretches of a constant strobe and with dense pseudo-random strobes. It runs three configurations (default, limit 2, window disabled) side by side. A behavioural model keeps a queue of accepted issue cycles and predicts `allow_o` and `viol_o` every cycle. A mismatch in either direction, a late release or an early release, is reported against the rule that the model says was binding.

// File: rtl/act_lim_pkg.sv
package act_lim_pkg;

  // Bits needed to hold values 0..n without wrapping; at least 1.
  function automatic int unsigned span_bits(input int unsigned n);
    int unsigned b;
    b = $clog2(n + 1);
    return (b == 0) ? 1 : b;
  endfunction

endpackage

// File: rtl/act_lim_spacer.sv
module act_lim_spacer
  import act_lim_pkg::*;
#(
  parameter int unsigned GAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  output logic ok_o
);

  localparam int unsigned CW = span_bits(GAP);
  localparam logic [CW-1:0] LOADV = (GAP > 0) ? CW'(GAP - 1) : '0;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = take_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (take_i)
      cnt_d = LOADV;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign ok_o = (cnt_q == '0);

  generate
    if (GAP > 1) begin : g_gap_chk
      // R2
      rrd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !ok_o);
    end
  endgenerate

  // R2
  rrd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o && !take_i) |=> ok_o);

endmodule

// File: rtl/act_lim_window.sv
module act_lim_window
  import act_lim_pkg::*;
#(
  parameter int unsigned WIN   = 32,
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  output logic ok_o
);

  generate
    if (WIN == 0) begin : g_off
      logic unused_in;
      assign unused_in = ^{clk, rst_n, take_i};
      assign ok_o = 1'b1;
    end else begin : g_on
      localparam int unsigned TW = span_bits(WIN);
      localparam int unsigned PW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
      localparam int unsigned CW = span_bits(LIMIT);
      localparam logic [TW-1:0] WIN_T  = TW'(WIN);
      localparam logic [PW-1:0] LAST_P = PW'(LIMIT - 1);
      localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);

      logic [TW-1:0]    now_q;
      logic [TW-1:0]    ts_q [LIMIT];
      logic [TW-1:0]    ts_d [LIMIT];
      logic [LIMIT-1:0] live_q, live_d, in_win;
      logic [PW-1:0]    ptr_q, ptr_d;
      logic [CW-1:0]    busy;
      logic [TW-1:0]    age [LIMIT];

      // Age of each slot; an entry stays live only while its age is inside the window.
      for (genvar i = 0; i < LIMIT; i++) begin : g_slot
        assign age[i]    = now_q - ts_q[i];
        assign in_win[i] = live_q[i] && (age[i] < WIN_T);
      end

      always_comb begin
        busy = '0;
        for (int i = 0; i < LIMIT; i++)
          busy = busy + CW'(in_win[i]);
      end

      assign ok_o = (busy < LIM_C);

      always_comb begin
        live_d = in_win;
        ptr_d  = ptr_q;
        for (int i = 0; i < LIMIT; i++)
          ts_d[i] = ts_q[i];
        if (take_i) begin
          live_d[ptr_q] = 1'b1;
          ts_d[ptr_q]   = now_q;
          ptr_d         = (ptr_q == LAST_P) ? '0 : ptr_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          now_q  <= '0;
          live_q <= '0;
          ptr_q  <= '0;
        end else begin
          now_q  <= now_q + 1'b1;
          live_q <= live_d;
          if (take_i)
            ptr_q <= ptr_d;
        end
      end

      for (genvar i = 0; i < LIMIT; i++) begin : g_ts
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            ts_q[i] <= '0;
          else if (take_i && (ptr_q == PW'(i)))
            ts_q[i] <= ts_d[i];
        end
      end

      // R3
      win_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (live_q != '0));

      // R4
      win_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_o |-> ($countones(live_q) == LIMIT));
    end
  endgenerate

endmodule

// File: rtl/act_limiter.sv
module act_limiter #(
  parameter int unsigned RRD_CYC   = 5,
  parameter int unsigned XAW_CYC   = 32,
  parameter int unsigned ACT_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic allow_o,
  output logic viol_o
);

  logic gap_ok, win_ok, take, viol_d, viol_q;

  assign allow_o = gap_ok && win_ok;
  assign take    = act_i && allow_o;
  assign viol_d  = act_i && !allow_o;

  act_lim_spacer #(.GAP(RRD_CYC)) u_spacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take),
    .ok_o   (gap_ok)
  );

  act_lim_window #(.WIN(XAW_CYC), .LIMIT(ACT_LIMIT)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take),
    .ok_o   (win_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      viol_q <= 1'b0;
    else
      viol_q <= viol_d;
  end

  assign viol_o = viol_q;

  // R7
  viol_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && !allow_o) |=> viol_o);

  // R8
  viol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_i || allow_o) |=> !viol_o);

endmodule

// File: tb/act_limiter_tb.sv
module act_limiter_tb;

  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act = 1'b0;
  bit   done = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  for (genvar g = 0; g < 3; g++) begin : g_cfg
    localparam int RR = (g == 0) ? 5 : (g == 1) ? 2 : 3;
    localparam int XW = (g == 0) ? 32 : (g == 1) ? 20 : 0;
    localparam int LM = (g == 1) ? 2 : 4;

    logic allow, viol;
    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int last = 0;
    bit have_last = 0;
    bit exp_viol = 0;
    int q[$];

    act_limiter #(.RRD_CYC(RR), .XAW_CYC(XW), .ACT_LIMIT(LM)) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (act),
      .allow_o (allow),
      .viol_o  (viol)
    );

    always @(negedge clk) begin
      if (rst_n && !done) begin
        bit gap_ok, win_ok, exp_allow;
        string tg;
        if (XW > 0)
          while (q.size() > 0 && (cyc - q[0]) >= XW) void'(q.pop_front());
        gap_ok    = !have_last || ((cyc - last) >= RR);
        win_ok    = (XW == 0) || (q.size() < LM);
        exp_allow = gap_ok && win_ok;
        if (cyc == 0) tg = "R1";
        else if (XW == 0) tg = "R5";
        else if (LM == 2) tg = "R6";
        else if (!gap_ok) tg = "R2";
        else if (q.size() < LM) tg = "R4";
        else tg = "R3";
        checks++;
        if (allow !== exp_allow) begin
          bad++;
          $display("FAIL %s cfg%0d cyc %0d allow actual=%b expected=%b", tg, g, cyc, allow, exp_allow);
        end
        checks++;
        if (viol !== exp_viol) begin
          bad++;
          $display("FAIL %s cfg%0d cyc %0d viol actual=%b expected=%b",
                   (cyc == 0) ? "R1" : (exp_viol ? "R7" : "R8"), g, cyc, viol, exp_viol);
        end
        if (act && exp_allow) begin
          q.push_back(cyc);
          last = cyc;
          have_last = 1;
        end
        exp_viol = act && !exp_allow;
        cyc++;
      end
    end
  end

  task automatic drive(input bit v);
    @(posedge clk);
    #1 act = v;
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // quiet cycles: R1 reset state
    repeat (4) drive(1'b0);
    // constant strobe: spacing and window release together (R2, R3, R7)
    repeat (300) drive(1'b1);
    repeat (60) drive(1'b0);
    // dense pseudo-random strobes
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[3]);
    end
    // sparse strobes: window never fills (R4)
    for (int i = 0; i < 400; i++) drive((i % 11) == 0);
    // bursts separated by exact window gaps
    for (int b = 0; b < 20; b++) begin
      repeat (8) drive(1'b1);
      repeat (24 + b) drive(1'b0);
    end
    drive(1'b0);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d",
             g_cfg[0].checks + g_cfg[1].checks + g_cfg[2].checks,
             g_cfg[0].bad + g_cfg[1].bad + g_cfg[2].bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d",
               g_cfg[0].checks + g_cfg[1].checks + g_cfg[2].checks + 1,
               g_cfg[0].bad + g_cfg[1].bad + g_cfg[2].bad + 1);
      $finish;
    end
  end

endmodule